// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

A synchronous controller that sits between a simple valid/ready request port and an asynchronous 32K x 8 static RAM whose data pins are shared between input and output. Each accepted request is one byte, either a read or a write. The controller turns that request into a timed sequence of chip-select, write-enable and output-enable strobes. It drives the address and the outgoing byte and controls the enable of its own data drivers. For reads, it captures the returned byte and hands it back with a one-cycle completion pulse.

Every interval is a whole number of clock cycles. Each one is computed from a clock-period parameter and the slowest-grade minimum times, rounded up, with a floor of one cycle. Writes are controlled by write-enable with output-enable held high for the whole write. The controller waits a turnaround interval, covering the memory's output-disable-to-high-impedance time, before it turns on its own drivers. Between any two accesses there is at least one cycle with chip select high. New requests are taken only in that idle state.

Top module: `asram_ctl`

## Requirements
- R1: After reset and in every idle cycle, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_write`=1 selects a write and 0 selects a read. `req_ready` is 0 in the cycle after a request is taken and stays 0 until the access is complete.
- R3: A write begins with `mem_cs_n`=0, `mem_we_n`=1 and `mem_oe_n`=1, and the drivers off, for TURN = ceil(T_OHZ_NS/CLK_NS) cycles (minimum 1; 3 at the defaults). `mem_oe_n` stays 1 through every cycle in which `mem_we_n` is 0.
- R4: `mem_we_n` is then 0 for WP cycles, where WP is the largest of the rounded-up write-pulse, data-setup, select-to-end and address-to-end times (6 at the defaults). During these cycles `mem_dq_oe` is 1, and `mem_dq_out` and `mem_addr` hold the accepted byte and address.
- R5: A write ends with `mem_we_n` and `mem_cs_n` rising in the same cycle. The drivers and the byte are held for that one cycle, and the controller then returns to idle.
- R6: A read holds `mem_cs_n`=0, `mem_oe_n`=0 and `mem_we_n`=1, with a stable address and the drivers off, for RD = ceil(max(T_RC_NS, T_AA_NS, T_ACS_NS)/CLK_NS) cycles (7 at the defaults).
- R7: `mem_dq_in` is sampled at the clock edge that closes the last read cycle. `rsp_valid` is 1 for exactly the following cycle, with that byte on `rsp_rdata`, and `rsp_rdata` keeps it until the next read completes.
- R8: `mem_cs_n` falls only in the cycle after a request was taken in idle, so at least one cycle with chip select high lies between accesses.
- R9: The cycle in which `rsp_valid` is 1 is an idle cycle. A new request may be taken in that same cycle.
- R10: `mem_dq_oe` is never 1 while `mem_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (15) | Byte address |
| req_wdata | input | DATA_W (8) | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse: read byte available |
| rsp_rdata | output | DATA_W (8) | Captured read byte |
| mem_addr | output | ADDR_W (15) | Memory address pins |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_we_n | output | 1 | Active-low write enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | DATA_W (8) | Byte driven onto the shared bus |
| mem_dq_oe | output | 1 | Enable of the controller's bus drivers |
| mem_dq_in | input | DATA_W (8) | Byte read from the shared bus |

## Verification
The read-completion pulse and the acceptance of the next request can land in the same cycle, because the response is issued in the first idle cycle after a read. The bench provokes this by issuing a request right behind each read, so the request is already waiting when the read finishes. It counts the cycles in which `rsp_valid`, `req_valid` and `req_ready` are all 1. It then confirms that the next access starts with chip select falling one cycle later and that the completed byte is still correct. The bench's memory model holds back valid read data until RD cycles of read strobes have elapsed, so a capture made too early returns a marker byte instead of stored data.

// File: rtl/asram_pkg.sv
// Package: shared state type and cycle-count helper for the SRAM controller.
// Assumes every time argument is a non-negative number of nanoseconds.
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WTURN = 3'd1,
        ST_WPULS = 3'd2,
        ST_WEND  = 3'd3,
        ST_RACC  = 3'd4
    } asram_state_e;

    // Whole cycles covering t_ns at period clk_ns, never fewer than one.
    function automatic int cyc_of(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_timer.sv
// Interval down-counter. A start pulse loads the interval length. 'done' is
// high on the last cycle of the interval. Assumes start_val >= 1.
module asram_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] start_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Load on start, otherwise count down to zero and stop there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= start_val - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/asram_fsm.sv
// Strobe sequencer. It steps through idle, write turnaround, write pulse,
// write end and read access. The strobes are registered from the next state,
// so the pins change cleanly on the edge that enters a state. Assumes each
// count parameter is >= 1 and fits in CNT_W bits.
module asram_fsm
    import asram_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int TURN_CYC = 3,
    parameter int WP_CYC   = 6,
    parameter int RD_CYC   = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output logic req_ready,
    output logic accept,
    output logic capture,
    output logic cs_n,
    output logic we_n,
    output logic oe_n,
    output logic dq_oe
);
    asram_state_e     st_q, st_d;
    logic             t_start, t_done;
    logic [CNT_W-1:0] t_val;

    asram_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (t_start),
        .start_val(t_val),
        .done     (t_done)
    );

    assign req_ready = (st_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign capture   = (st_q == ST_RACC) && t_done;

    // Next state and interval load for each step of an access.
    always_comb begin
        st_d    = st_q;
        t_start = 1'b0;
        t_val   = CNT_W'(1);
        unique case (st_q)
            ST_IDLE: if (req_valid) begin
                t_start = 1'b1;
                if (req_write) begin
                    st_d  = ST_WTURN;
                    t_val = CNT_W'(TURN_CYC);
                end else begin
                    st_d  = ST_RACC;
                    t_val = CNT_W'(RD_CYC);
                end
            end
            ST_WTURN: if (t_done) begin
                st_d    = ST_WPULS;
                t_start = 1'b1;
                t_val   = CNT_W'(WP_CYC);
            end
            ST_WPULS: if (t_done) st_d = ST_WEND;
            ST_WEND:  st_d = ST_IDLE;
            ST_RACC:  if (t_done) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // State register and strobes registered from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cs_n  <= 1'b1;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            st_q  <= st_d;
            cs_n  <= !(st_d inside {ST_WTURN, ST_WPULS, ST_RACC});
            we_n  <= (st_d != ST_WPULS);
            oe_n  <= (st_d != ST_RACC);
            dq_oe <= (st_d inside {ST_WPULS, ST_WEND});
        end
    end
endmodule

// File: rtl/asram_dpath.sv
// Address, write-byte and read-byte registers. It latches the request on
// accept and captures the bus on the last read cycle. Assumes accept and
// capture never coincide; the sequencer guarantees this.
module asram_dpath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rsp_q
);
    // Hold the request fields from accept until the next accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Capture the read byte and raise the one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            rsp_q   <= 1'b0;
        end else begin
            rsp_q <= capture;
            if (capture) rdata_q <= dq_in;
        end
    end
endmodule

// File: rtl/asram_ctl.sv
// Top level: a valid/ready byte request port driving an asynchronous
// 32K x 8 SRAM with shared data pins. Every interval comes from CLK_NS and
// the slowest-grade minimum times. Assumes the external bus is resolved
// outside the block from mem_dq_out and mem_dq_oe.
module asram_ctl
    import asram_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int CLK_NS    = 10,
    parameter int T_RC_NS   = 70,
    parameter int T_AA_NS   = 70,
    parameter int T_ACS_NS  = 70,
    parameter int T_WP_NS   = 50,
    parameter int T_CW_NS   = 60,
    parameter int T_AW_NS   = 60,
    parameter int T_DW_NS   = 30,
    parameter int T_OHZ_NS  = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int TURN_CYC = cyc_of(T_OHZ_NS, CLK_NS);
    localparam int WP_CYC   = imax(imax(cyc_of(T_WP_NS, CLK_NS), cyc_of(T_DW_NS, CLK_NS)),
                                   imax(cyc_of(T_CW_NS, CLK_NS), cyc_of(T_AW_NS, CLK_NS)));
    localparam int RD_CYC   = imax(cyc_of(T_RC_NS, CLK_NS),
                                   imax(cyc_of(T_AA_NS, CLK_NS), cyc_of(T_ACS_NS, CLK_NS)));
    localparam int MAX_CYC  = imax(TURN_CYC, imax(WP_CYC, RD_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    logic accept, capture;

    asram_fsm #(
        .CNT_W(CNT_W), .TURN_CYC(TURN_CYC), .WP_CYC(WP_CYC), .RD_CYC(RD_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_ready(req_ready),
        .accept   (accept),
        .capture  (capture),
        .cs_n     (mem_cs_n),
        .we_n     (mem_we_n),
        .oe_n     (mem_oe_n),
        .dq_oe    (mem_dq_oe)
    );

    asram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .capture  (capture),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .dq_in    (mem_dq_in),
        .addr_q   (mem_addr),
        .wdata_q  (mem_dq_out),
        .rdata_q  (rsp_rdata),
        .rsp_q    (rsp_valid)
    );
endmodule

// File: rtl/asram_ctl_chk.sv
// Protocol checker for asram_ctl. It watches only the top-level ports and is
// attached with the bind below. Assumes a synchronous active-low reset.
module asram_ctl_chk #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    p_busy_after_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_oe_high_in_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    p_drive_in_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_dq_oe && !mem_cs_n));

    p_pulse_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_dq_out) && $stable(mem_addr)));

    p_end_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_cs_n && mem_dq_oe));

    p_addr_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_cs_after_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cs_n) |-> $past(req_valid && req_ready));

    p_rsp_in_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

    p_no_fight_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);
endmodule

bind asram_ctl asram_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_out(mem_dq_out),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/asram_ctl_bench.sv
// Scoreboard bench for asram_ctl with a cycle-level SRAM model. The model
// holds back valid read data until RD strobe cycles have elapsed.
module asram_ctl_bench;
    localparam int CLK_NS = 10;
    localparam int TURN_E = 3;   // ceil(25/10)
    localparam int WP_E   = 6;   // max(ceil 50, 30, 60, 60 over 10)
    localparam int RD_E   = 7;   // ceil(70/10)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [14:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    int checks = 0;
    int fails  = 0;
    int coinc  = 0;

    logic [7:0] model_m  [int];
    logic [7:0] shadow_m [int];
    logic [7:0] exp_q    [$];

    always #(CLK_NS/2) clk = ~clk;

    asram_ctl u_asram_ctl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    // Record one check and report it when it fails.
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Driver: called at a negedge. It presents a request and returns at the
    // negedge after the request is taken, pushing the expected read byte.
    task automatic issue(input bit wr, input logic [14:0] a, input logic [7:0] d);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (wr) shadow_m[int'(a)] = d;
        else    exp_q.push_back(shadow_m.exists(int'(a)) ? shadow_m[int'(a)] : 8'h00);
    endtask

    // Monitor and memory model, sampled 1 ns after each falling edge.
    bit prev_cs = 1'b1, prev_we = 1'b1, prev_ready = 1'b1, prev_take = 1'b0;
    int turn_cnt = 0, wp_cnt = 0, rd_len = 0, rd_age = 0;
    bit wr_act = 1'b0;
    int wr_a = 0;
    logic [7:0] wr_d = '0;
    always begin
        @(negedge clk);
        #1;
        if (rst_n) begin
            if (!mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe) turn_cnt++;
            if (!mem_we_n) begin
                wp_cnt++;
                chk(mem_oe_n && mem_dq_oe, "R3 oe high/drive on in pulse",
                    {mem_oe_n, mem_dq_oe}, 2'b11);
            end
            if (!mem_we_n && prev_we) chk(turn_cnt == TURN_E, "R3 turnaround", turn_cnt, TURN_E);
            if (mem_we_n && !prev_we) begin
                chk(wp_cnt == WP_E, "R4 pulse length", wp_cnt, WP_E);
                chk(mem_cs_n && mem_dq_oe, "R5 end hold", {mem_cs_n, mem_dq_oe}, 2'b11);
                wp_cnt = 0;
            end
            if (!mem_cs_n && !mem_oe_n) rd_len++;
            if (mem_cs_n && !prev_cs) begin
                if (rd_len > 0) chk(rd_len == RD_E, "R6 read window", rd_len, RD_E);
                rd_len = 0;
                turn_cnt = 0;
            end
            if (!mem_cs_n && prev_cs) chk(prev_ready, "R8 cs from idle", prev_ready, 1);
            if (prev_take) chk(!req_ready, "R2 busy after take", req_ready, 0);
            if (mem_dq_oe && !mem_oe_n) chk(1'b0, "R10 driver fight", 1, 0);
            if (rsp_valid) begin
                chk(req_ready, "R9 rsp in idle", req_ready, 1);
                if (req_valid && req_ready) coinc++;
                if (exp_q.size() == 0) chk(1'b0, "R7 unexpected rsp", rsp_rdata, 0);
                else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    chk(rsp_rdata == e, "R7 read data", rsp_rdata, e);
                end
            end
            // Memory model: write on the CS/WE overlap, committed when it ends.
            if (!mem_cs_n && !mem_we_n) begin
                wr_act = 1'b1;
                wr_a = int'(mem_addr);
                wr_d = mem_dq_out;
            end else if (wr_act) begin
                model_m[wr_a] = wr_d;
                wr_act = 1'b0;
            end
            if (!mem_cs_n && !mem_oe_n && mem_we_n) rd_age++;
            else rd_age = 0;
            mem_dq_in = (rd_age >= RD_E)
                ? (model_m.exists(int'(mem_addr)) ? model_m[int'(mem_addr)] : 8'h00)
                : 8'hEE;
            prev_take = req_valid && req_ready;
            prev_cs = mem_cs_n;
            prev_we = mem_we_n;
            prev_ready = req_ready;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset and idle state
        chk(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes high",
            {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
        chk(!mem_dq_oe && req_ready && !rsp_valid, "R1 idle outputs",
            {mem_dq_oe, req_ready, rsp_valid}, 3'b010);
        // R4, R7: write patterns, then read back
        issue(1'b1, 15'h0000, 8'h55);
        issue(1'b1, 15'h7FFF, 8'hAA);
        issue(1'b1, 15'h1234, 8'hFF);
        issue(1'b1, 15'h4321, 8'h00);
        issue(1'b0, 15'h0000, 8'h00);
        issue(1'b0, 15'h7FFF, 8'h00);
        issue(1'b0, 15'h1234, 8'h00);
        issue(1'b0, 15'h4321, 8'h00);
        // R9: read immediately followed by a write, then by a read
        issue(1'b0, 15'h2222, 8'h00);
        issue(1'b1, 15'h2222, 8'h3C);
        issue(1'b0, 15'h2222, 8'h00);
        issue(1'b1, 15'h0001, 8'hC3);
        issue(1'b0, 15'h0001, 8'h00);
        for (int i = 0; i < 6; i++) issue(1'b1, 15'(16'h0100 + i), 8'(8'h10 * i + 1));
        for (int i = 0; i < 6; i++) issue(1'b0, 15'(16'h0100 + i), 8'h00);
        // R7: rsp_rdata holds after the pulse
        repeat (12) @(negedge clk);
        chk(!rsp_valid, "R7 pulse low", rsp_valid, 0);
        chk(rsp_rdata == 8'h51, "R7 rdata held", rsp_rdata, 8'h51);
        chk(exp_q.size() == 0, "R7 all responses", exp_q.size(), 0);
        chk(coinc > 0, "R9 rsp with accept", coinc, 1);
        chk(req_ready && mem_cs_n, "R1 back to idle", {req_ready, mem_cs_n}, 2'b11);
        finish_run();
    end
endmodule